// File: doc/BRIEF.md
# Real-Time Sequence Number Checker

This block receives the sequence number carried in each arriving test frame, together with a stream index and a valid strobe. It checks each number against what that stream should deliver next. Traffic does not have to stop for this check. For each of its independent streams it counts missing frames and records the longest single jump. It also tells a frame that arrives late, and fills a hole, apart from a frame that repeats a number already seen. Every anomaly raises a one-cycle error pulse tagged with its kind and stream, so a capture engine can use it as a trigger.

Each stream keeps a 64-position record of which recent numbers are still missing. A late number whose position is marked counts as reordered and is removed from the loss count. Any other number that lies behind the expected value counts as a duplicate. Numbers are 32-bit and wrap around. The direction of a number is judged by the sign of its modular difference from the expected value. A restart input clears one stream, so the next frame on that stream starts it again. Counters are read through a combinational select port.

Top module: `seqchk_top`

## Requirements
- R1: After reset, every stream reads zero on all four counters, and `seq_err` is low.
- R2: The first frame on a stream after reset or restart sets the expected value to its number plus 1. It changes no counter and raises no error.
- R3: A frame whose number equals the expected value changes no counter and raises no error. The expected value then becomes that number plus 1, modulo 2^32, so 0xFFFFFFFF followed by 0 is in order.
- R4: A frame ahead of the expected value by g, where g is in 1 to 2^31-1 as a signed modular difference, adds g to the loss counter. It raises the burst maximum to g if g is larger, and it reports error kind 2'b01. The burst maximum never decreases except on restart.
- R5: A frame behind the expected value at distance k is reordered when its number is still marked missing. Here k = expected-1-number, and the frame qualifies when k < 64. Such a frame increments the reorder counter, decrements the loss counter, clears its mark, and reports kind 2'b10.
- R6: Any other frame behind the expected value is a duplicate. This covers a number that was not marked missing and one at distance 64 or more. A duplicate increments the duplicate counter, leaves the loss counter unchanged, and reports kind 2'b11.
- R7: Streams are independent. A frame on one stream changes no counter of another.
- R8: `restart` clears all state and counters of `restart_stream`. A frame on the same stream in the same cycle is handled as that stream's first frame.
- R9: `seq_err` is high for exactly the one cycle after the clock edge that takes the faulty frame. `err_kind` and `err_stream` identify the fault during that cycle.
- R10: The read port outputs the counters of `rd_stream` combinationally from state, and reflects a frame from the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame's sequence number is present |
| in_stream | input | 3 | Stream index of the frame |
| in_seq | input | 32 | Sequence number of the frame |
| restart | input | 1 | Clear one stream |
| restart_stream | input | 3 | Stream to clear |
| rd_stream | input | 3 | Stream selected for readout |
| rd_lost | output | 32 | Outstanding lost frames of the selected stream |
| rd_burst | output | 32 | Largest single gap of the selected stream |
| rd_reord | output | 32 | Reordered frames of the selected stream |
| rd_dup | output | 32 | Duplicated frames of the selected stream |
| seq_err | output | 1 | One-cycle anomaly pulse |
| err_kind | output | 2 | 01 loss, 10 reorder, 11 duplicate |
| err_stream | output | 3 | Stream of the anomaly |

## Verification
A wrong expected value shows at the ports on the very next frame of that stream. An in-order frame would then pulse `seq_err` as a gap or a duplicate, and the loss counter would jump. A corrupted missing-number record stays hidden until a late frame arrives. At that point the frame is classed as a duplicate instead of reordered, or the other way round, and the reorder and duplicate counters disagree with the expected pattern. The directed sequences therefore always follow a gap with late arrivals at known distances, including one beyond the 64-position record. They also check the read port after every frame.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_FIRST,
        CLS_INORDER,
        CLS_GAP,
        CLS_REORDER,
        CLS_DUP
    } seq_cls_e;

    localparam logic [1:0] ERR_NONE  = 2'b00;
    localparam logic [1:0] ERR_LOSS  = 2'b01;
    localparam logic [1:0] ERR_REORD = 2'b10;
    localparam logic [1:0] ERR_DUP   = 2'b11;

endpackage

// File: rtl/seqchk_classify.sv
module seqchk_classify
    import seqchk_pkg::*;
#(
    parameter int SEQ_W = 32,
    parameter int WIN   = 64,
    localparam int WIN_W = $clog2(WIN)
) (
    input  logic             valid,
    input  logic             started,
    input  logic [SEQ_W-1:0] expct,
    input  logic [WIN-1:0]   miss,
    input  logic [SEQ_W-1:0] seq,
    output seq_cls_e         cls,
    output logic [SEQ_W-1:0] gap,
    output logic [WIN_W-1:0] back_off
);

    localparam logic [SEQ_W-1:0] WIN_L = SEQ_W'(WIN);

    logic [SEQ_W-1:0] diff;
    logic [SEQ_W-1:0] behind;

    always_comb begin
        diff     = seq - expct;
        behind   = expct - seq - SEQ_W'(1);
        gap      = '0;
        back_off = behind[WIN_W-1:0];
        if (!valid) begin
            cls = CLS_NONE;
        end else if (!started) begin
            cls = CLS_FIRST;
        end else if (diff == '0) begin
            cls = CLS_INORDER;
        end else if (!diff[SEQ_W-1]) begin
            cls = CLS_GAP;
            gap = diff;
        end else if ((behind < WIN_L) && miss[behind[WIN_W-1:0]]) begin
            cls = CLS_REORDER;
        end else begin
            cls = CLS_DUP;
        end
    end

endmodule

// File: rtl/seqchk_window.sv
module seqchk_window
    import seqchk_pkg::*;
#(
    parameter int SEQ_W = 32,
    parameter int WIN   = 64,
    localparam int WIN_W = $clog2(WIN)
) (
    input  seq_cls_e         cls,
    input  logic [WIN-1:0]   miss_in,
    input  logic [SEQ_W-1:0] gap,
    input  logic [WIN_W-1:0] back_off,
    output logic [WIN-1:0]   miss_out
);

    localparam logic [WIN-1:0]   ONE_W   = WIN'(1);
    localparam logic [SEQ_W-1:0] SAT_GAP = SEQ_W'(WIN - 1);

    logic [WIN_W-1:0] shamt;
    logic [WIN-1:0]   fill;

    always_comb begin
        shamt = gap[WIN_W-1:0];
        fill  = ((ONE_W << shamt) - ONE_W) << 1;
        unique case (cls)
            CLS_FIRST:   miss_out = '0;
            CLS_INORDER: miss_out = miss_in << 1;
            CLS_GAP: begin
                if (gap >= SAT_GAP) miss_out = ~ONE_W;
                else                miss_out = ((miss_in << shamt) << 1) | fill;
            end
            CLS_REORDER: miss_out = miss_in & ~(ONE_W << back_off);
            default:     miss_out = miss_in;
        endcase
    end

endmodule

// File: rtl/seqchk_top.sv
module seqchk_top
    import seqchk_pkg::*;
#(
    parameter int NSTRM = 8,
    parameter int SEQ_W = 32,
    parameter int CNT_W = 32,
    parameter int WIN   = 64,
    localparam int SID_W = $clog2(NSTRM),
    localparam int WIN_W = $clog2(WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SID_W-1:0] in_stream,
    input  logic [SEQ_W-1:0] in_seq,
    input  logic             restart,
    input  logic [SID_W-1:0] restart_stream,
    input  logic [SID_W-1:0] rd_stream,
    output logic [CNT_W-1:0] rd_lost,
    output logic [CNT_W-1:0] rd_burst,
    output logic [CNT_W-1:0] rd_reord,
    output logic [CNT_W-1:0] rd_dup,
    output logic             seq_err,
    output logic [1:0]       err_kind,
    output logic [SID_W-1:0] err_stream
);

    typedef struct packed {
        logic             started;
        logic [SEQ_W-1:0] expct;
        logic [WIN-1:0]   miss;
        logic [CNT_W-1:0] lost;
        logic [CNT_W-1:0] burst;
        logic [CNT_W-1:0] reord;
        logic [CNT_W-1:0] dup;
    } strm_t;

    typedef struct packed {
        strm_t [NSTRM-1:0] s;
        logic              err;
        logic [1:0]        kind;
        logic [SID_W-1:0]  estrm;
    } regs_t;

    regs_t r_d, r_q;

    strm_t            cur;
    strm_t            nxt;
    seq_cls_e         cls;
    logic [SEQ_W-1:0] gap;
    logic [CNT_W-1:0] gap_c;
    logic [WIN_W-1:0] back_off;
    logic [WIN-1:0]   miss_new;

    always_comb begin
        cur = r_q.s[in_stream];
        if (restart && (restart_stream == in_stream)) cur = '0;
    end

    seqchk_classify #(.SEQ_W(SEQ_W), .WIN(WIN)) u_cls (
        .valid    (in_valid),
        .started  (cur.started),
        .expct    (cur.expct),
        .miss     (cur.miss),
        .seq      (in_seq),
        .cls      (cls),
        .gap      (gap),
        .back_off (back_off)
    );

    seqchk_window #(.SEQ_W(SEQ_W), .WIN(WIN)) u_win (
        .cls      (cls),
        .miss_in  (cur.miss),
        .gap      (gap),
        .back_off (back_off),
        .miss_out (miss_new)
    );

    assign gap_c = CNT_W'(gap);

    always_comb begin
        r_d      = r_q;
        r_d.err  = 1'b0;
        r_d.kind = ERR_NONE;
        nxt      = cur;
        if (restart) r_d.s[restart_stream] = '0;
        unique case (cls)
            CLS_FIRST: begin
                nxt.started = 1'b1;
                nxt.expct   = in_seq + SEQ_W'(1);
                nxt.miss    = miss_new;
            end
            CLS_INORDER: begin
                nxt.expct = in_seq + SEQ_W'(1);
                nxt.miss  = miss_new;
            end
            CLS_GAP: begin
                nxt.expct = in_seq + SEQ_W'(1);
                nxt.miss  = miss_new;
                nxt.lost  = cur.lost + gap_c;
                if (gap_c > cur.burst) nxt.burst = gap_c;
                r_d.err   = 1'b1;
                r_d.kind  = ERR_LOSS;
                r_d.estrm = in_stream;
            end
            CLS_REORDER: begin
                nxt.miss  = miss_new;
                nxt.lost  = cur.lost - CNT_W'(1);
                nxt.reord = cur.reord + CNT_W'(1);
                r_d.err   = 1'b1;
                r_d.kind  = ERR_REORD;
                r_d.estrm = in_stream;
            end
            CLS_DUP: begin
                nxt.dup   = cur.dup + CNT_W'(1);
                r_d.err   = 1'b1;
                r_d.kind  = ERR_DUP;
                r_d.estrm = in_stream;
            end
            default: ;
        endcase
        if (in_valid) r_d.s[in_stream] = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_lost    = r_q.s[rd_stream].lost;
    assign rd_burst   = r_q.s[rd_stream].burst;
    assign rd_reord   = r_q.s[rd_stream].reord;
    assign rd_dup     = r_q.s[rd_stream].dup;
    assign seq_err    = r_q.err;
    assign err_kind   = r_q.kind;
    assign err_stream = r_q.estrm;

    // R2 / R3: accepted in-order, first or ahead frames move expected to number+1
    p_exp_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_INORDER || cls == CLS_GAP || cls == CLS_FIRST)
        |=> r_q.s[$past(in_stream)].expct == $past(in_seq) + SEQ_W'(1));

    // R2: a first frame never raises an error
    p_first_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_FIRST) |=> !seq_err);

    // R5: reorder removes exactly one loss
    p_reord_lost_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_REORDER)
        |=> r_q.s[$past(in_stream)].lost == $past(cur.lost) - CNT_W'(1));

    // R6: duplicate leaves the loss counter alone
    p_dup_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_DUP)
        |=> r_q.s[$past(in_stream)].lost == $past(cur.lost));

    // R9: an error pulse always carries a kind
    p_err_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> err_kind != ERR_NONE);

    for (genvar gi = 0; gi < NSTRM; gi++) begin : g_chk
        // R4: burst maximum only grows unless the stream restarts
        p_burst_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(restart && restart_stream == SID_W'(gi))
            |=> r_q.s[gi].burst >= $past(r_q.s[gi].burst));
    end

endmodule

// File: tb/sim_seqchk_top.sv
module sim_seqchk_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_stream = '0;
    logic [31:0] in_seq = '0;
    logic        restart = 1'b0;
    logic [2:0]  restart_stream = '0;
    logic [2:0]  rd_stream = '0;
    logic [31:0] rd_lost, rd_burst, rd_reord, rd_dup;
    logic        seq_err;
    logic [1:0]  err_kind;
    logic [2:0]  err_stream;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic        e;
    logic [1:0]  k;
    logic [2:0]  es;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqchk_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_stream(in_stream),
        .in_seq(in_seq), .restart(restart), .restart_stream(restart_stream),
        .rd_stream(rd_stream), .rd_lost(rd_lost), .rd_burst(rd_burst),
        .rd_reord(rd_reord), .rd_dup(rd_dup), .seq_err(seq_err),
        .err_kind(err_kind), .err_stream(err_stream)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input int s, input logic [31:0] q);
        @(negedge clk);
        in_valid = 1'b1; in_stream = 3'(s); in_seq = q;
        @(posedge clk); #1;
        e = seq_err; k = err_kind; es = err_stream;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic counters(input int s, input string req,
                            input logic [31:0] lo, input logic [31:0] bu,
                            input logic [31:0] ro, input logic [31:0] du);
        rd_stream = 3'(s); #1;
        chk({req, " lost"}, rd_lost, lo);
        chk({req, " burst"}, rd_burst, bu);
        chk({req, " reord"}, rd_reord, ro);
        chk({req, " dup"}, rd_dup, du);
    endtask

    task automatic t_reset;
        for (int s = 0; s < 8; s++) counters(s, "R1 reset", 0, 0, 0, 0);
        chk("R1 seq_err", {31'b0, seq_err}, 0);
    endtask

    task automatic t_inorder;
        send(0, 100); chk("R2 first no err", {31'b0, e}, 0);
        send(0, 101); chk("R3 inorder no err", {31'b0, e}, 0);
        send(0, 102); chk("R3 inorder no err", {31'b0, e}, 0);
        counters(0, "R3 inorder", 0, 0, 0, 0);
    endtask

    task automatic t_gap;
        send(0, 106);
        chk("R4 gap err", {31'b0, e}, 1);
        chk("R4 gap kind", {30'b0, k}, 1);
        counters(0, "R4 gap3", 3, 3, 0, 0);
        // R9: pulse lasts a single cycle
        @(posedge clk); #1;
        chk("R9 pulse width", {31'b0, seq_err}, 0);
        send(0, 108);
        counters(0, "R4 gap1 burst kept", 4, 3, 0, 0);
    endtask

    task automatic t_reorder;
        send(0, 104);
        chk("R5 kind", {30'b0, k}, 2);
        counters(0, "R5 reorder", 3, 3, 1, 0);
        send(0, 104);
        chk("R6 kind", {30'b0, k}, 3);
        counters(0, "R6 dup repeat", 3, 3, 1, 1);
        send(0, 108);
        chk("R6 dup latest kind", {30'b0, k}, 3);
        counters(0, "R6 dup latest", 3, 3, 1, 2);
        send(0, 109);
        chk("R3 resume no err", {31'b0, e}, 0);
    endtask

    task automatic t_far;
        send(1, 1000);
        send(1, 1200);
        chk("R9 err_stream", {29'b0, es}, 1);
        counters(1, "R4 big gap", 199, 199, 0, 0);
        send(1, 1100);
        chk("R6 far kind", {30'b0, k}, 3);
        counters(1, "R6 beyond window", 199, 199, 0, 1);
        send(1, 1201);
        chk("R3 after far", {31'b0, e}, 0);
    endtask

    task automatic t_wrap;
        send(2, 32'hFFFF_FFFE);
        send(2, 32'hFFFF_FFFF);
        chk("R3 pre-wrap", {31'b0, e}, 0);
        send(2, 32'h0000_0000);
        chk("R3 wrap", {31'b0, e}, 0);
        send(2, 32'h0000_0003);
        chk("R4 after wrap", {30'b0, k}, 1);
        counters(2, "R4 wrap gap", 2, 2, 0, 0);
        send(2, 32'hFFFF_FFFF);
        chk("R6 behind wrap kind", {30'b0, k}, 3);
    endtask

    task automatic t_indep;
        counters(3, "R7 untouched", 0, 0, 0, 0);
        counters(0, "R7 retained", 3, 3, 1, 2);
    endtask

    task automatic t_restart;
        @(negedge clk);
        restart = 1'b1; restart_stream = 3'd0;
        @(negedge clk);
        restart = 1'b0;
        counters(0, "R8 cleared", 0, 0, 0, 0);
        counters(1, "R8 other kept", 199, 199, 0, 1);
        send(0, 5);
        chk("R8 first after restart", {31'b0, e}, 0);
        @(negedge clk);
        restart = 1'b1; restart_stream = 3'd1;
        in_valid = 1'b1; in_stream = 3'd1; in_seq = 50;
        @(posedge clk); #1;
        chk("R8 same-cycle first", {31'b0, seq_err}, 0);
        @(negedge clk);
        restart = 1'b0; in_valid = 1'b0;
        counters(1, "R8 same-cycle clear", 0, 0, 0, 0);
        send(1, 51);
        chk("R8 follow inorder", {31'b0, e}, 0);
        send(1, 53);
        chk("R8 gap after restart", {30'b0, k}, 1);
        counters(1, "R10 readout", 1, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset;
        t_inorder;
        t_gap;
        t_reorder;
        t_far;
        t_wrap;
        t_indep;
        t_restart;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule